// File: doc/BRIEF.md
# Serial Peripheral Port with Prescaled Clock Divider

This block is a register-mapped serial peripheral port. It can run as a bus master, generating the serial clock and an active-low select, or as a slave clocked by an external serial clock. A frame carries either 8 or 16 bits and always shifts most significant bit first. Software sets the clock polarity, the clock phase and the clock divider. The divider is the product of a 3-bit prescaler and a power of two. The serial clock period is (P+1)·2^(R+1) system clocks.

Software starts a frame by writing the data byte registers. In 16-bit frames the low byte is staged first, and the write of the high byte launches the frame. When a frame completes, the received word is placed in the same two byte registers. Reading the low byte releases the receive buffer. If a frame completes while the buffer is still full, the new word is dropped and a sticky overrun flag is raised.

The shift engine is a single state machine:
- **IDLE**: no frame is in progress.
- **SETUP**: master only. Select is low and the clock is idle for one half period.
- **SHIFT**: master only. The engine produces 2·N clock edges.
- **HOLD**: master only. Select stays low for one more half period after the last edge.
- **SLAVE**: an externally clocked frame is in progress.

The transitions are:
- IDLE→SETUP on a launch in master mode.
- SETUP→SHIFT on the first baud tick.
- SHIFT→HOLD on the last edge.
- HOLD→IDLE on the next tick, which completes the frame.
- IDLE→SLAVE when the external select falls in slave mode.
- SLAVE→IDLE on the last sample (the frame completes) or when the select rises (the frame is abandoned).
- Any state→IDLE when the enable bit is cleared.

Top module: `spi_port`

## Requirements
- R1: After reset, the registers at offsets 0, 1, 2, 4 and 5 read 0x00. The status register at offset 3 reads 0x80. The outputs are ss_n_o=1 and sclk_o=0.
- R2: Register map.
  - Offset 0, control: bit 6 enable, bit 4 master (1) or slave (0), bit 3 clock polarity, bit 2 clock phase. The other bits read 0.
  - Offset 1, width: bit 0 set selects 16-bit frames and clear selects 8-bit frames.
  - Offset 2, divider: bits 6:4 hold the prescaler P and bits 3:0 hold the rate R.
  - A mode number m maps to polarity m[1] and phase m[0].
- R3: In master mode, consecutive serial clock edges are (P+1)·2^R system clocks apart. A rate value above 8 acts as 8.
- R4: Whenever ss_n_o is high, sclk_o sits at the polarity level. With phase 0, data is sampled on the leading edge of each bit. With phase 1, it is sampled on the trailing edge.
- R5: Bits shift MSB first. In master mode, ss_n_o stays low for the whole frame, and the frame carries exactly 2·N clock edges (N = 8 or 16).
- R6: In 8-bit mode, a write to offset 4 launches a frame carrying that byte.
- R7: In 16-bit mode, a write to offset 4 only stages the low byte. A later write to offset 5 launches a frame carrying {offset 5 byte, offset 4 byte}.
- R8: Status bit 7 (transmit empty) clears on a launch and sets at the end of the frame. Status bit 5 (receive full) sets at the end of the frame.
- R9: After a frame, offset 5 reads the received high byte and offset 4 reads the low byte. A read of offset 4 clears receive full.
- R10: Data writes are ignored while transmit empty is clear or while enable is clear.
- R11: When a frame ends with receive full already set, the new word is dropped and status bit 0 (overrun) sets. A read of the status register clears the overrun bit.
- R12: In slave mode, while ss_n_i is low, the block samples mosi_i and drives miso_o on edges of sclk_i, following the same polarity and phase rules. It transmits the staged word and receives into the data registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| sclk_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| ss_n_o | output | 1 | Master active-low select |
| sclk_i | input | 1 | Slave serial clock |
| ss_n_i | input | 1 | Slave active-low select |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |

## Verification
Read data is combinational, so the bench samples reg_rdata one time unit after it sets the address, and register writes are visible one cycle later. In master mode, ss_n_o falls on the clock after the launch write and rises one half period after the final edge. The status flags and the received bytes appear on the following clock, so the bench waits for ss_n_o to rise plus three clocks before it reads them. The bench polls no status register during a frame, because a status read clears the overrun bit.

In slave mode, the inputs pass through a two-stage synchronizer and an edge detector, which puts the reaction about three clocks behind each input change. The bench holds every half period of sclk_i for eight clocks and samples miso_o just before its own next edge. Edge spacing and edge counts in master mode are measured each cycle at the falling clock edge.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam logic [2:0] ADR_CTRL   = 3'd0;
    localparam logic [2:0] ADR_WIDTH  = 3'd1;
    localparam logic [2:0] ADR_DIV    = 3'd2;
    localparam logic [2:0] ADR_STAT   = 3'd3;
    localparam logic [2:0] ADR_DLO    = 3'd4;
    localparam logic [2:0] ADR_DHI    = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_SLAVE
    } eng_state_t;

    typedef struct packed {
        logic en;
        logic master;
        logic cpol;
        logic cpha;
    } port_cfg_t;

endpackage

// File: rtl/spi_port_regs.sv
module spi_port_regs
    import spi_port_pkg::*;
#(
    parameter int NARROW = 8,
    parameter int PW     = 3,
    parameter int RW     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                rd,
    input  logic [2:0]          addr,
    input  logic [NARROW-1:0]   wdata,
    output logic [NARROW-1:0]   rdata,
    input  logic                done,
    input  logic [2*NARROW-1:0] rx_word,
    output port_cfg_t           cfg,
    output logic                wide,
    output logic [PW-1:0]       presc,
    output logic [RW-1:0]       rate,
    output logic                launch,
    output logic [2*NARROW-1:0] tx_word,
    output logic                tx_empty,
    output logic                rx_full,
    output logic                ovr
);

    logic [NARROW-1:0] tx_lo, tx_hi, rx_lo, rx_hi;
    logic              data_ok;
    logic              lo_wr;

    assign data_ok = wr && cfg.en && tx_empty;
    assign lo_wr   = data_ok && (addr == ADR_DLO);
    assign launch  = data_ok && ((addr == ADR_DLO && !wide) || (addr == ADR_DHI && wide));

    // word handed to the engine: the byte being written is forwarded on launch
    always_comb begin
        if (launch && wide)      tx_word = {wdata, tx_lo};
        else if (launch)         tx_word = {{NARROW{1'b0}}, wdata};
        else if (wide)           tx_word = {tx_hi, tx_lo};
        else                     tx_word = {{NARROW{1'b0}}, tx_lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= '0;
            wide     <= 1'b0;
            presc    <= '0;
            rate     <= '0;
            tx_lo    <= '0;
            tx_hi    <= '0;
            rx_lo    <= '0;
            rx_hi    <= '0;
            tx_empty <= 1'b1;
            rx_full  <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            if (wr && addr == ADR_CTRL) begin
                cfg.en     <= wdata[6];
                cfg.master <= wdata[4];
                cfg.cpol   <= wdata[3];
                cfg.cpha   <= wdata[2];
            end
            if (wr && addr == ADR_WIDTH) wide <= wdata[0];
            if (wr && addr == ADR_DIV) begin
                presc <= wdata[RW +: PW];
                rate  <= wdata[RW-1:0];
            end
            if (lo_wr)              tx_lo <= wdata;
            if (launch && wide)     tx_hi <= wdata;
            if (done)               tx_empty <= 1'b1;
            if (launch)             tx_empty <= 1'b0;
            if (rd && addr == ADR_DLO)  rx_full <= 1'b0;
            if (rd && addr == ADR_STAT) ovr     <= 1'b0;
            if (done) begin
                if (rx_full) begin
                    ovr <= 1'b1;
                end else begin
                    rx_lo   <= rx_word[NARROW-1:0];
                    rx_hi   <= rx_word[2*NARROW-1:NARROW];
                    rx_full <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (addr)
            ADR_CTRL:  rdata = {1'b0, cfg.en, 1'b0, cfg.master, cfg.cpol, cfg.cpha, 2'b00};
            ADR_WIDTH: rdata = {{(NARROW-1){1'b0}}, wide};
            ADR_DIV:   rdata = {{(NARROW-PW-RW){1'b0}}, presc, rate};
            ADR_STAT:  rdata = {tx_empty, 1'b0, rx_full, 4'b0000, ovr};
            ADR_DLO:   rdata = rx_lo;
            ADR_DHI:   rdata = rx_hi;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_port_baud.sv
module spi_port_baud #(
    parameter int PW       = 3,
    parameter int RW       = 4,
    parameter int RATE_MAX = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] presc,
    input  logic [RW-1:0] rate,
    output logic          tick
);

    localparam int CW = PW + 1 + RATE_MAX;

    logic [RW-1:0] rate_eff;
    logic [CW-1:0] half;
    logic [CW-1:0] cnt;

    assign rate_eff = (rate > RW'(RATE_MAX)) ? RW'(RATE_MAX) : rate;
    assign half     = (CW'(presc) + CW'(1)) << rate_eff;
    assign tick     = run && (cnt == half - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine
    import spi_port_pkg::*;
#(
    parameter int NARROW = 8,
    parameter int WMAX   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  port_cfg_t       cfg,
    input  logic            wide,
    input  logic            start,
    input  logic            tx_valid,
    input  logic [WMAX-1:0] tx_word,
    input  logic            tick,
    input  logic            sclk_i,
    input  logic            ss_n_i,
    input  logic            mosi_i,
    input  logic            miso_i,
    output logic            run,
    output logic            done,
    output logic [WMAX-1:0] rx_word,
    output logic            sclk_o,
    output logic            ss_n_o,
    output logic            mosi_o,
    output logic            miso_o
);

    localparam int EW = $clog2(2*WMAX);
    localparam int BW = $clog2(WMAX);

    eng_state_t      state, nxt;
    logic [WMAX-1:0] tx_sh, rx_sh;
    logic [EW-1:0]   edge_cnt, edge_last;
    logic [BW-1:0]   bit_cnt, bit_last;
    logic            ph, first, wide_q;
    logic [2:0]      sck_p, ssn_p, mosi_p;
    logic            sck_q, ssn_q;
    logic            m_ev, s_ev, ev, lead, samp, din, last_m, last_s, ssn_fall;

    // two-stage synchronizers for the slave-side pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p  <= '0;
            ssn_p  <= '1;
            mosi_p <= '0;
            sck_q  <= 1'b0;
            ssn_q  <= 1'b1;
        end else begin
            sck_p  <= {sck_p[1:0], sclk_i};
            ssn_p  <= {ssn_p[1:0], ss_n_i};
            mosi_p <= {mosi_p[1:0], mosi_i};
            sck_q  <= sck_p[1];
            ssn_q  <= ssn_p[1];
        end
    end

    assign edge_last = wide_q ? EW'(2*WMAX-1) : EW'(2*NARROW-1);
    assign bit_last  = wide_q ? BW'(WMAX-1)   : BW'(NARROW-1);
    assign m_ev      = (state == ST_SHIFT) && tick;
    assign s_ev      = (state == ST_SLAVE) && (sck_p[1] != sck_q);
    assign ev        = m_ev || s_ev;
    assign lead      = (state == ST_SLAVE) ? (sck_p[1] != cfg.cpol) : !ph;
    assign samp      = lead ^ cfg.cpha;
    assign din       = (state == ST_SLAVE) ? mosi_p[1] : miso_i;
    assign last_m    = m_ev && (edge_cnt == edge_last);
    assign last_s    = s_ev && samp && (bit_cnt == bit_last);
    assign ssn_fall  = ssn_q && !ssn_p[1];

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cfg.en && cfg.master && start)       nxt = ST_SETUP;
                else if (cfg.en && !cfg.master && ssn_fall) nxt = ST_SLAVE;
            end
            ST_SETUP: if (tick)   nxt = ST_SHIFT;
            ST_SHIFT: if (last_m) nxt = ST_HOLD;
            ST_HOLD:  if (tick)   nxt = ST_IDLE;
            ST_SLAVE: if (ssn_p[1] || last_s) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (!cfg.en) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh    <= '0;
            rx_sh    <= '0;
            edge_cnt <= '0;
            bit_cnt  <= '0;
            ph       <= 1'b0;
            first    <= 1'b0;
            wide_q   <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= (state == ST_HOLD && tick) || last_s;
            if (state == ST_IDLE && nxt != ST_IDLE) begin
                if (cfg.master || tx_valid)
                    tx_sh <= wide ? tx_word
                                  : {tx_word[NARROW-1:0], {(WMAX-NARROW){1'b0}}};
                else
                    tx_sh <= '0;
                rx_sh    <= '0;
                edge_cnt <= '0;
                bit_cnt  <= '0;
                first    <= 1'b1;
                wide_q   <= wide;
            end else if (ev) begin
                first <= 1'b0;
                if (samp) begin
                    rx_sh   <= {rx_sh[WMAX-2:0], din};
                    bit_cnt <= bit_cnt + BW'(1);
                end else if (!(cfg.cpha && first)) begin
                    tx_sh <= {tx_sh[WMAX-2:0], 1'b0};
                end
                if (m_ev) begin
                    ph       <= !ph;
                    edge_cnt <= edge_cnt + EW'(1);
                end
            end
            if (nxt == ST_IDLE) ph <= 1'b0;
        end
    end

    assign run     = (state == ST_SETUP) || (state == ST_SHIFT) || (state == ST_HOLD);
    assign ss_n_o  = !run;
    assign sclk_o  = cfg.cpol ^ ph;
    assign mosi_o  = run ? tx_sh[WMAX-1] : 1'b0;
    assign miso_o  = (state == ST_SLAVE) ? tx_sh[WMAX-1] : 1'b0;
    assign rx_word = rx_sh;

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int NARROW   = 8,
    parameter int PW       = 3,
    parameter int RW       = 4,
    parameter int RATE_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [NARROW-1:0] reg_wdata,
    output logic [NARROW-1:0] reg_rdata,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              ss_n_o,
    input  logic              sclk_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o
);

    localparam int WMAX = 2 * NARROW;

    port_cfg_t       cfg;
    logic            wide, launch, tx_empty, rx_full, ovr, done, run, tick;
    logic [PW-1:0]   presc;
    logic [RW-1:0]   rate;
    logic [WMAX-1:0] tx_word, rx_word;

    spi_port_regs #(.NARROW(NARROW), .PW(PW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .done(done), .rx_word(rx_word),
        .cfg(cfg), .wide(wide), .presc(presc), .rate(rate), .launch(launch),
        .tx_word(tx_word), .tx_empty(tx_empty), .rx_full(rx_full), .ovr(ovr)
    );

    spi_port_baud #(.PW(PW), .RW(RW), .RATE_MAX(RATE_MAX)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .presc(presc), .rate(rate), .tick(tick)
    );

    spi_port_engine #(.NARROW(NARROW), .WMAX(WMAX)) u_eng (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .wide(wide), .start(launch),
        .tx_valid(!tx_empty), .tx_word(tx_word), .tick(tick),
        .sclk_i(sclk_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_i(miso_i),
        .run(run), .done(done), .rx_word(rx_word), .sclk_o(sclk_o),
        .ss_n_o(ss_n_o), .mosi_o(mosi_o), .miso_o(miso_o)
    );

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk_o,
    input logic ss_n_o,
    input logic mosi_o,
    input logic cpol,
    input logic tx_empty,
    input logic rx_full,
    input logic ovr,
    input logic done
);

    // R4: clock rests at the polarity level while select is high
    a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> (sclk_o == cpol));

    // R8: select only falls once a word has been launched
    a_r8_launch_before_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n_o) |-> !tx_empty);

    // R8: receive full only rises right after a completed frame
    a_r8_full_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(done));

    // R11: overrun only rises when the buffer was already full
    a_r11_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(rx_full));

    // R5: inside a frame the data line only moves together with the clock
    a_r5_mosi_moves_with_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n_o && $past(!ss_n_o) && $stable(sclk_o)) |-> $stable(mosi_o));

endmodule

bind spi_port spi_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .ss_n_o(ss_n_o), .mosi_o(mosi_o),
    .cpol(cfg.cpol), .tx_empty(tx_empty), .rx_full(rx_full), .ovr(ovr), .done(done)
);

// File: tb/test_spi_port.sv
`timescale 1ns/1ps
module test_spi_port;

    localparam int CLK_P = 10;
    localparam int SH    = 8;   // slave half period in clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sclk_o, mosi_o, ss_n_o, miso_o;
    logic       miso_i = 1'b0, sclk_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_port i_spi_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .ss_n_o(ss_n_o),
        .sclk_i(sclk_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // bench-side slave model for master frames
    logic        m_on = 1'b0, b_cpol = 1'b0, b_cpha = 1'b0;
    logic [15:0] b_pat = '0, cap = '0;
    int          b_hp = 1, di = 0, edges = 0, hp_bad = 0, cyc = 0, last_e = 0;
    logic        first_e = 1'b1, prev_ss = 1'b1, prev_sck = 1'b0, lead_e;

    always @(negedge clk) begin
        cyc++;
        if (m_on) begin
            if (prev_ss && !ss_n_o) begin
                di = (b_hp < 0) ? 0 : 0;
                edges = 0; hp_bad = 0; first_e = 1'b1; cap = '0;
            end
        end
        prev_ss = ss_n_o;
        prev_sck = sclk_o;
    end

    // separate edge process keeps frame start and edge handling in one order
    int          n_bits = 8;
    logic        pss = 1'b1, psck = 1'b0;
    always @(negedge clk) begin
        if (m_on) begin
            if (pss && !ss_n_o) begin
                di = n_bits - 1;
                if (!b_cpha) miso_i = b_pat[di];
            end else if (!ss_n_o && sclk_o != psck) begin
                lead_e = (psck == b_cpol);
                if (!first_e && (cyc - last_e) != b_hp) hp_bad++;
                first_e = 1'b0;
                last_e = cyc;
                edges++;
                if (lead_e ^ b_cpha) begin
                    cap = {cap[14:0], mosi_o};
                end else if (!b_cpha) begin
                    di = di - 1;
                    if (di >= 0) miso_i = b_pat[di];
                end else begin
                    if (di >= 0) miso_i = b_pat[di];
                    di = di - 1;
                end
            end
        end
        pss = ss_n_o;
        psck = sclk_o;
    end

    task automatic wait_frame_end();
        int t = 0;
        while (ss_n_o && t < 50) begin @(negedge clk); t++; end
        t = 0;
        while (!ss_n_o && t < 40000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_master(input int mode, input bit w, input int p, input int r,
                              input logic [15:0] txv, input logic [15:0] pat,
                              input bit intrude, input bit do_read);
        logic [7:0] d, hi;
        logic [15:0] mask;
        int n;
        n = w ? 16 : 8;
        mask = w ? 16'hFFFF : 16'h00FF;
        wr(3'd1, {7'b0, w});
        wr(3'd2, {1'b0, 3'(p), 4'(r)});
        wr(3'd0, 8'h50 | (8'(mode[1]) << 3) | (8'(mode[0]) << 2));
        b_cpol = mode[1]; b_cpha = mode[0]; b_pat = pat & mask; n_bits = n;
        b_hp = (p + 1) << ((r > 8) ? 8 : r);
        m_on = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 idle sclk level", sclk_o, mode[1]);
        wr(3'd4, txv[7:0]);
        if (w) begin
            repeat (3) @(negedge clk);
            chk("R7 low byte alone launches nothing", ss_n_o, 1);
            wr(3'd5, txv[15:8]);
        end
        if (intrude) begin
            repeat (4) @(negedge clk);
            wr(3'd4, ~txv[7:0]);
        end
        wait_frame_end();
        m_on = 1'b0;
        chk("R5 edge count", edges, 2*n);
        chk("R3 half period spacing errors", hp_bad, 0);
        chk("R5/R6/R7 MSB-first transmitted word", cap & mask, txv & mask);
        chk("R4 sclk back at idle", sclk_o, mode[1]);
        if (do_read) begin
            rd(3'd3, d);
            chk("R8 status after frame", d, 8'hA0);
            rd(3'd5, hi);
            rd(3'd4, d);
            chk("R9/R4 received word", {hi, d} & mask, pat & mask);
            rd(3'd3, d);
            chk("R9 low read clears full", d, 8'h80);
        end
    endtask

    task automatic run_slave(input int mode, input bit w,
                             input logic [15:0] txv, input logic [15:0] pat);
        logic [7:0] d, hi;
        logic [15:0] scap, mask;
        int n;
        n = w ? 16 : 8;
        mask = w ? 16'hFFFF : 16'h00FF;
        scap = '0;
        sclk_i = mode[1]; ss_n_i = 1'b1; mosi_i = 1'b0;
        wr(3'd1, {7'b0, w});
        wr(3'd0, 8'h40 | (8'(mode[1]) << 3) | (8'(mode[0]) << 2));
        repeat (5) @(negedge clk);
        wr(3'd4, txv[7:0]);
        if (w) wr(3'd5, txv[15:8]);
        @(negedge clk); ss_n_i = 1'b0;
        repeat (SH) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            if (!mode[0]) begin
                mosi_i = pat[i];
                repeat (SH) @(negedge clk);
                scap = {scap[14:0], miso_o};
                sclk_i = !mode[1];
                repeat (SH) @(negedge clk);
                sclk_i = mode[1];
            end else begin
                sclk_i = !mode[1];
                mosi_i = pat[i];
                repeat (SH) @(negedge clk);
                scap = {scap[14:0], miso_o};
                sclk_i = mode[1];
                repeat (SH) @(negedge clk);
            end
        end
        repeat (SH) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (SH) @(negedge clk);
        chk("R12 slave transmitted word", scap & mask, txv & mask);
        rd(3'd3, d);
        chk("R12/R8 slave status", d, 8'hA0);
        rd(3'd5, hi);
        rd(3'd4, d);
        chk("R12 slave received word", {hi, d} & mask, pat & mask);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [15:0] tx, pt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reset register value", d, (a == 3) ? 8'h80 : 8'h00);
        end
        chk("R1 reset ss_n_o", ss_n_o, 1);
        chk("R1 reset sclk_o", sclk_o, 0);

        // R2 register readback
        wr(3'd0, 8'hFF); rd(3'd0, d); chk("R2 control readback", d, 8'h5C);
        wr(3'd1, 8'hFF); rd(3'd1, d); chk("R2 width readback", d, 8'h01);
        wr(3'd2, 8'hFF); rd(3'd2, d); chk("R2 divider readback", d, 8'h7F);

        // R10 disabled writes are ignored
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h10);
        wr(3'd4, 8'h33);
        repeat (20) @(negedge clk);
        chk("R10 disabled write no select", ss_n_o, 1);
        rd(3'd3, d); chk("R10 disabled write keeps tx empty", d, 8'h80);

        // master sweep over modes, widths, dividers
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 2; w++)
                for (int b = 0; b < 2; b++) begin
                    tx = 16'h9C35 + 16'(m) * 16'h0F13 + 16'(w) * 16'h3301 + 16'(b) * 16'h0707;
                    pt = {tx[7:0], tx[15:8]} ^ 16'h5A5A;
                    run_master(m, w[0], b ? 2 : 0, b ? 1 : 0, tx, pt, 1'b0, 1'b1);
                end

        // R3 rate clamp: rate 12 behaves as 8
        run_master(0, 1'b0, 1, 12, 16'h00A7, 16'h0064, 1'b0, 1'b1);

        // R10 write while busy ignored
        run_master(1, 1'b0, 3, 2, 16'h00C3, 16'h0011, 1'b1, 1'b1);
        repeat (60) @(negedge clk);
        chk("R10 busy write starts no frame", ss_n_o, 1);

        // R11 overrun
        run_master(2, 1'b0, 0, 1, 16'h0081, 16'h00E4, 1'b0, 1'b0);
        run_master(3, 1'b0, 0, 1, 16'h0018, 16'h0027, 1'b0, 1'b0);
        rd(3'd3, d); chk("R11 overrun flagged", d, 8'hA1);
        rd(3'd3, d); chk("R11 status read clears overrun", d, 8'hA0);
        rd(3'd4, d); chk("R11 first word kept", d, 8'hE4);
        rd(3'd3, d); chk("R11 buffer released", d, 8'h80);

        // R12 slave frames
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 2; w++) begin
                tx = 16'hB24D ^ (16'(m) * 16'h1357) ^ (16'(w) << 4);
                pt = ~tx ^ 16'h0F0F;
                run_slave(m, w[0], tx, pt);
            end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule